// File: doc/BRIEF.md
# Downspread Triangular Spread-Spectrum Offset Generator

This block produces a signed frequency-offset word for a fractional divider or a digitally controlled oscillator that synthesises a host clock and the bus-rate clock derived from it. The word follows a triangle: it starts at zero (nominal frequency), walks down to a programmable depth below nominal, turns around and walks back up to zero, and repeats. It never goes above zero, so the modulated clock never runs faster than nominal and its average stays close to the top of its allowed range. Fixed-rate outputs such as a 48 MHz or a crystal-rate reference are not fed from this word.

The offset is in units of 1/65536 of nominal frequency; the default depth of 393 is about 0.6 % below nominal. A prescaler turns the reference clock into step instants, and each step moves the word by a fixed amount, so the depth, step size and prescale ratio together set the modulation rate (tuned to a few tens of kHz so that downstream PLLs can follow). Spread is requested by holding the active-low enable low. When it is released, the word climbs back to zero at the normal step rate and holds there. A one-cycle flag marks the deepest point of each sweep.

Top module: `ssm_downspread_gen`

## Requirements
- R1: While rst_n is low at a rising edge, offset_o becomes 0 and trough_o 0; the first step after reset moves the offset downward.
- R2: The offset changes only on step instants, which fall on every TICK_DIV-th rising edge, the first on the TICK_DIV-th rising edge after rst_n is seen high; between steps offset_o holds.
- R3: offset_o, read as a two's-complement number, always lies in the range -DEPTH to 0 inclusive.
- R4: With spread_n low and the sweep heading down, each step lowers the offset by STEP; a step that would reach or pass -DEPTH sets it to exactly -DEPTH and turns the sweep upward.
- R5: With the sweep heading up, each step raises the offset by STEP; a step that would reach or pass 0 sets it to exactly 0 and the next enabled step heads down, so both halves take the same number of steps.
- R6: trough_o is high for exactly one clock cycle, the cycle in which the offset has just been set to -DEPTH by a downward step, and is low at all other times.
- R7: With spread_n high, each step raises the offset by STEP (clamped at 0), after which it holds at 0; no trough pulse occurs, even when the step would otherwise have reached -DEPTH.
- R8: When spread_n goes low with the offset at 0 a new downward sweep starts; when it goes low while the offset is still returning, the offset keeps rising to 0 before heading down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spread_n | input | 1 | Spread request, active low (0 = modulate, 1 = return to nominal) |
| offset_o | output | OFS_W | Signed frequency offset in 1/65536 of nominal, never positive |
| trough_o | output | 1 | One-cycle pulse at the deepest point of each sweep |

## Verification
The bench drives uninterrupted sweeps, which show that the step size, the floor clamp at a depth that is not a multiple of the step, and the ceiling clamp at zero are right, and that both halves are equal in length. It then releases the request during a downward half, during an upward half and one step before the floor, which separates a clean return to zero from a frozen or still-sweeping word and shows that the trough flag is suppressed. Re-enabling at zero and in the middle of a return tells apart the two ways a new sweep may start, and a reset in mid-sweep shows that the direction is forced back downward.

// File: rtl/ssm_pkg.sv
// Shared types for the downspread modulation generator.
package ssm_pkg;

    // Direction of the triangle sweep.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } sweep_dir_e;

endpackage

// File: rtl/ssm_step_timer.sv
// Step timer: divides the reference clock down to one-cycle step strobes,
// one every TICK_DIV cycles. Free-running; assumes TICK_DIV >= 1.
module ssm_step_timer #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_o
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign step_o = (cnt_q == LAST);

    // Count reference cycles, wrapping at the step instant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing_chk
            // R2: strobes never come back to back when the ratio exceeds one.
            a_r2_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                step_o |=> !step_o);
        end
    endgenerate

endmodule

// File: rtl/ssm_ramp.sv
// Triangle ramp engine: on each step strobe moves the offset by STEP,
// downward to -DEPTH and back up to zero while spread is requested, and
// only upward toward zero while it is not. Assumes 0 < DEPTH < 2**(OFS_W-1)
// and 0 < STEP <= DEPTH.
module ssm_ramp
    import ssm_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int DEPTH = 393,
    parameter int STEP  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_i,
    input  logic                    spread_n,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    trough_o
);
    localparam int EW = OFS_W + 1;
    localparam logic signed [EW-1:0] FLOOR_X = EW'(-DEPTH);
    localparam logic signed [EW-1:0] STEP_X  = EW'(STEP);
    localparam logic signed [EW-1:0] ZERO_X  = '0;

    logic signed [OFS_W-1:0] ofs_q, ofs_d;
    sweep_dir_e              dir_q, dir_d;
    logic                    trough_q, trough_d;
    logic signed [EW-1:0]    ofs_x, dn_x, up_x;
    logic                    hit_floor, hit_top;

    // Widen by one bit so the candidate values cannot wrap.
    assign ofs_x     = {ofs_q[OFS_W-1], ofs_q};
    assign dn_x      = ofs_x - STEP_X;
    assign up_x      = ofs_x + STEP_X;
    assign hit_floor = (dn_x <= FLOOR_X);
    assign hit_top   = (up_x >= ZERO_X);

    // Choose the next offset, direction and trough flag for this cycle.
    always_comb begin
        ofs_d    = ofs_q;
        dir_d    = dir_q;
        trough_d = 1'b0;
        if (step_i) begin
            if (!spread_n && (dir_q == DIR_DOWN)) begin
                if (hit_floor) begin
                    ofs_d    = FLOOR_X[OFS_W-1:0];
                    dir_d    = DIR_UP;
                    trough_d = 1'b1;
                end else begin
                    ofs_d = dn_x[OFS_W-1:0];
                end
            end else if (hit_top) begin
                ofs_d = '0;
                dir_d = DIR_DOWN;
            end else begin
                ofs_d = up_x[OFS_W-1:0];
                dir_d = DIR_UP;
            end
        end
    end

    // Hold ramp state; reset parks at nominal heading down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q    <= '0;
            dir_q    <= DIR_DOWN;
            trough_q <= 1'b0;
        end else begin
            ofs_q    <= ofs_d;
            dir_q    <= dir_d;
            trough_q <= trough_d;
        end
    end

    assign offset_o = ofs_q;
    assign trough_o = trough_q;

    // R2: the offset moves only after a step strobe.
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(ofs_q));

    // R4: an ordinary downward step lowers the offset by exactly STEP.
    a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !spread_n && dir_q == DIR_DOWN && !hit_floor)
        |=> (ofs_q + OFS_W'(STEP)) == $past(ofs_q));

    // R6: the trough flag only appears at the floor and lasts one cycle.
    a_r6_trough_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
        trough_q |-> (ofs_q == FLOOR_X[OFS_W-1:0]));
    a_r6_trough_single: assert property (@(posedge clk) disable iff (!rst_n)
        trough_q |=> !trough_q);

    // R7: with spread released, a step never raises the trough flag.
    a_r7_no_trough_off: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && spread_n) |=> !trough_q);

endmodule

// File: rtl/ssm_downspread_gen.sv
// Downspread spread-spectrum offset generator. Produces a signed offset in
// 1/65536 of nominal frequency following a triangle between 0 and -DEPTH.
// Modulation period is 2*ceil(DEPTH/STEP)*TICK_DIV reference cycles.
// Assumes a single clock domain and a synchronous active-low reset.
module ssm_downspread_gen #(
    parameter int OFS_W    = 16,
    parameter int DEPTH    = 393,
    parameter int STEP     = 2,
    parameter int TICK_DIV = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_n,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    trough_o
);
    logic step;

    // Step strobe generation.
    ssm_step_timer #(
        .TICK_DIV (TICK_DIV)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_o (step)
    );

    // Triangle ramp with clean return to nominal.
    ssm_ramp #(
        .OFS_W (OFS_W),
        .DEPTH (DEPTH),
        .STEP  (STEP)
    ) u_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (step),
        .spread_n (spread_n),
        .offset_o (offset_o),
        .trough_o (trough_o)
    );

    // R3: the word stays within the downspread window.
    a_r3_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o <= 0) && (offset_o >= -DEPTH));

    // R1: reset leaves the output at nominal with no trough flag.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (offset_o == '0) && !trough_o);

endmodule

// File: tb/ssm_downspread_gen_bench.sv
module ssm_downspread_gen_bench;
    localparam int OFS_W = 16;
    localparam int DEPTH = 10;
    localparam int STEP  = 3;
    localparam int TDIV  = 2;
    localparam int N     = 34;

    // One row per step: spread_n driven, expected offset, expected trough.
    localparam bit SPR_N [N] = '{0,0,0,0,0,0,0,0,0,0, 1,1,1,1, 0,0,0,0,0,
                                 1,1,1,1, 0,0,0, 1,1,1, 0,0,1,0,0};
    localparam int EXP_OFS [N] = '{-3,-6,-9,-10,-7,-4,-1,0,-3,-6, -3,0,0,0,
                                   -3,-6,-9,-10,-7, -4,-1,0,0, -3,-6,-9,
                                   -6,-3,0, -3,-6,-3,0,-3};
    localparam bit EXP_TR [N] = '{0,0,0,1,0,0,0,0,0,0, 0,0,0,0, 0,0,0,1,0,
                                  0,0,0,0, 0,0,0, 0,0,0, 0,0,0,0,0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spread_n = 1'b0;
    logic signed [OFS_W-1:0] offset;
    logic trough;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssm_downspread_gen #(
        .OFS_W (OFS_W), .DEPTH (DEPTH), .STEP (STEP), .TICK_DIV (TDIV)
    ) u_ssm_downspread_gen (
        .clk (clk), .rst_n (rst_n), .spread_n (spread_n),
        .offset_o (offset), .trough_o (trough)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Advance to the next step instant and sample; also check the hold cycle.
    task automatic one_step(input int prev);
        @(posedge clk); @(negedge clk);
        chk("R2 hold", int'(offset), prev);
        chk("R6 no pulse between steps", int'(trough), 0);
        @(posedge clk); @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int prev;
        int cyc;
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 offset in reset", int'(offset), 0);
        chk("R1 trough in reset", int'(trough), 0);
        rst_n = 1'b1;
        prev = 0;

        // Table walk.
        for (int i = 0; i < N; i++) begin
            spread_n = SPR_N[i];
            one_step(prev);
            if (SPR_N[i]) tag = "R7";
            else if (i == 14 || i >= 32) tag = "R8";
            else if (EXP_OFS[i] > prev) tag = "R5";
            else tag = "R4";
            chk(tag, int'(offset), EXP_OFS[i]);
            chk("R6 trough", int'(trough), int'(EXP_TR[i]));
            chk("R3 window", int'(offset >= -DEPTH && offset <= 0), 1);
            prev = EXP_OFS[i];
        end

        // Reset in mid-sweep, then the first step must head down.
        one_step(prev);
        chk("R4 before reset", int'(offset), -6);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1 offset after mid reset", int'(offset), 0);
        chk("R1 trough after mid reset", int'(trough), 0);
        rst_n = 1'b1;
        one_step(0);
        chk("R1 first step down", int'(offset), -STEP);

        // Sweep length between troughs: 8 steps of 2 cycles.
        cyc = 0;
        while (!trough && cyc < 100) begin
            @(posedge clk); @(negedge clk); cyc++;
        end
        chk("R6 trough reached", int'(trough), 1);
        cyc = 0;
        @(posedge clk); @(negedge clk); cyc++;
        while (!trough && cyc < 100) begin
            @(posedge clk); @(negedge clk); cyc++;
        end
        chk("R5 sweep period cycles", cyc, 16);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule